// File: doc/BRIEF.md
# Quadrature Position Counter

This block follows the angular position of a shaft from a two-channel incremental encoder. The two channels, A and B, are square waves a quarter period apart. The order in which they rise shows which way the shaft turns. Both channels arrive asynchronously. Each passes through a two-stage synchronizer, and a rising edge is then found by comparing the synchronized level with its value one cycle earlier.

A single direction flag records the sense of rotation. It changes only when channel B rises, and it takes the synchronized level of channel A at that moment. A high flag means the shaft is turning forward (A leads B) and the count goes up. A low flag means the count goes down. A rising edge on either channel moves a signed 16-bit position register by one step in the flagged direction.

The position and its step strobe form an output stream with no ready input. `step_valid` marks each cycle in which `position` has just taken a counting step. There is no back-pressure: a consumer that needs every step must sample on every strobe cycle. A synchronous clear returns the position to zero and the flag to forward.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `position` is 0, `dir_up` is 1 and `step_valid` is 0.
- R2: If a channel is first sampled high at clock edge k after being sampled low at edge k-1, the resulting step reaches `position` at edge k+2 and not earlier.
- R3: `dir_up` changes only on a synchronized rising edge of B, and then takes the synchronized level of A. The value 1 means count up and 0 means count down.
- R4: Each synchronized rising edge of A or B changes `position` by +1 when the direction is up and by -1 when it is down. Falling edges leave `position` unchanged.
- R5: A step caused by a B rising edge uses the direction sampled on that same edge.
- R6: When A and B rise in the same cycle, `position` moves by exactly one step.
- R7: `position` is 16-bit two's complement and wraps: 32767 (0x7FFF) plus one gives -32768 (0x8000), and 0 minus one gives -1 (0xFFFF).
- R8: `step_valid` is high for exactly the one cycle after each edge at which a step was applied, and `position` holds its value whenever `step_valid` is low and no clear was applied.
- R9: A high `clr` at a clock edge sets `position` to 0, `dir_up` to 1 and `step_valid` to 0, and this overrides any step due at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of position and direction |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| position | output | 16 | Signed shaft position count |
| dir_up | output | 1 | Current direction flag, 1 = up |
| step_valid | output | 1 | One-cycle strobe after each counting step |

## Verification
A wrong direction flag shows on `dir_up` one cycle after the B edge that set it. From the next counted edge on, it also makes `position` drift in the wrong sense. A lost or doubled edge in the synchronizer or edge detector shows as a wrong `position` value three cycles after the input changes, and every later value stays offset by the same amount. For that reason the bench compares position, direction and strobe against a behavioural model on every clock, so a fault is reported in the cycle it first appears.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;
  localparam int NUM_CH   = 2;
  localparam int CH_A     = 0;
  localparam int CH_B     = 1;
  localparam int SYNC_LEN = 2;
  localparam logic FLAG_UP   = 1'b1;
  localparam logic FLAG_DOWN = 1'b0;
endpackage

// File: rtl/qpc_sync.sv
`timescale 1ns/1ps
module qpc_sync #(
  parameter int N_CH   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] din,
  output logic [N_CH-1:0] lvl
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[c]};
    end
    assign lvl[c] = chain[STAGES-1];
  end
endmodule

// File: rtl/qpc_edge.sv
`timescale 1ns/1ps
module qpc_edge #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] lvl,
  output logic [N_CH-1:0] rise
);
  logic [N_CH-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
endmodule

// File: rtl/qpc_dir.sv
`timescale 1ns/1ps
module qpc_dir
  import qpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample_en,
  input  logic sample_lvl,
  output logic dir_q,
  output logic dir_next
);
  always_comb dir_next = sample_en ? sample_lvl : dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dir_q <= FLAG_UP;
    else if (clr) dir_q <= FLAG_UP;
    else          dir_q <= dir_next;
  end
endmodule

// File: rtl/qpc_count.sv
`timescale 1ns/1ps
module qpc_count #(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step_en,
  input  logic                    count_up,
  output logic signed [WIDTH-1:0] pos,
  output logic                    step_valid
);
  localparam logic signed [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      step_valid <= 1'b0;
    end else if (clr) begin
      pos        <= '0;
      step_valid <= 1'b0;
    end else begin
      step_valid <= step_en;
      if (step_en) pos <= count_up ? pos + ONE : pos - ONE;
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    enc_a,
  input  logic                    enc_b,
  output logic signed [WIDTH-1:0] position,
  output logic                    dir_up,
  output logic                    step_valid
);
  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] rise;
  logic rise_a, rise_b, lvl_a;
  logic dir_next;
  logic step_en;

  assign raw_in[CH_A] = enc_a;
  assign raw_in[CH_B] = enc_b;

  qpc_sync #(.N_CH(NUM_CH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .lvl(lvl)
  );

  qpc_edge #(.N_CH(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
  );

  assign rise_a  = rise[CH_A];
  assign rise_b  = rise[CH_B];
  assign lvl_a   = lvl[CH_A];
  assign step_en = |rise;

  qpc_dir u_dir (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .sample_en(rise_b), .sample_lvl(lvl_a),
    .dir_q(dir_up), .dir_next(dir_next)
  );

  qpc_count #(.WIDTH(WIDTH)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .step_en(step_en), .count_up(dir_next),
    .pos(position), .step_valid(step_valid)
  );
endmodule

// File: rtl/qpc_checker.sv
`timescale 1ns/1ps
module qpc_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [WIDTH-1:0] position,
  input logic             dir_up,
  input logic             step_valid,
  input logic             rise_a,
  input logic             rise_b,
  input logic             lvl_a
);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (position == '0) && dir_up && !step_valid);

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && dir_up) |-> position == $past(position) + WIDTH'(1));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !dir_up) |-> position == $past(position) - WIDTH'(1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_valid && !$past(clr)) |-> $stable(position));

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_b && !clr) |=> $stable(dir_up));

  assert_dir_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_b && !clr) |=> dir_up == $past(lvl_a));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_a && rise_b && !clr) |=> step_valid);
endmodule

bind quad_pos_counter qpc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .position(position),
  .dir_up(dir_up), .step_valid(step_valid),
  .rise_a(rise_a), .rise_b(rise_b), .lvl_a(lvl_a)
);

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic enc_a = 1'b0;
  logic enc_b = 1'b0;
  logic signed [15:0] position;
  logic dir_up, step_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  quad_pos_counter uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enc_a(enc_a), .enc_b(enc_b),
    .position(position), .dir_up(dir_up), .step_valid(step_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: sample history per channel, newest first
  bit ha[$];
  bit hb[$];
  logic [15:0] m_pos;
  bit m_dir, m_stb;

  always @(posedge clk) begin
    if (!rst_n) begin
      ha = '{0, 0, 0, 0};
      hb = '{0, 0, 0, 0};
      m_pos = 16'h0000;
      m_dir = 1'b1;
      m_stb = 1'b0;
    end else begin
      bit ra, rb;
      ha.push_front(enc_a); void'(ha.pop_back());
      hb.push_front(enc_b); void'(hb.pop_back());
      ra = ha[2] && !ha[3];
      rb = hb[2] && !hb[3];
      if (clr) begin
        m_pos = 16'h0000; m_dir = 1'b1; m_stb = 1'b0;
      end else begin
        if (rb) m_dir = ha[2];
        if (ra || rb) m_pos = m_dir ? m_pos + 16'd1 : m_pos - 16'd1;
        m_stb = ra || rb;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(position == m_pos, "R4", "model position", int'(position), int'(m_pos));
      chk(dir_up == m_dir, "R3", "model direction", int'(dir_up), int'(m_dir));
      chk(step_valid == m_stb, "R8", "model strobe", int'(step_valid), int'(m_stb));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run hung actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 while reset is held
    chk(position == 16'sd0, "R1", "reset position", int'(position), 0);
    chk(dir_up == 1'b1, "R1", "reset dir", int'(dir_up), 1);
    chk(step_valid == 1'b0, "R1", "reset strobe", int'(step_valid), 0);
    rst_n = 1'b1;
    tick(1);
    chk(position == 16'sd0 && dir_up && !step_valid, "R1", "after release",
        int'(position), 0);

    // R2 latency: no step at edges k, k+1, step at k+2
    enc_a = 1'b1;
    tick(2);
    chk(position == 16'sd0, "R2", "too early", int'(position), 0);
    tick(1);
    chk(position == 16'sd1, "R2", "step arrived", int'(position), 1);
    chk(step_valid == 1'b1, "R8", "strobe high", int'(step_valid), 1);
    tick(1);
    chk(step_valid == 1'b0, "R8", "strobe one cycle", int'(step_valid), 0);
    enc_a = 1'b0; tick(4);

    // Forward rotation: A leads B, two steps per period (R4)
    for (int i = 0; i < 5; i++) begin
      enc_a = 1'b1; tick(3); enc_b = 1'b1; tick(3);
      enc_a = 1'b0; tick(3); enc_b = 1'b0; tick(3);
    end
    tick(4);
    chk(position == 16'sd11, "R4", "forward count", int'(position), 11);
    chk(dir_up == 1'b1, "R3", "forward dir", int'(dir_up), 1);

    // R5: B rises with A low, the same step goes down
    enc_b = 1'b1; tick(3);
    chk(position == 16'sd10, "R5", "same-cycle direction", int'(position), 10);
    chk(dir_up == 1'b0, "R3", "reverse dir", int'(dir_up), 0);
    enc_a = 1'b1; tick(3); enc_b = 1'b0; tick(3); enc_a = 1'b0; tick(3);
    for (int i = 0; i < 3; i++) begin
      enc_b = 1'b1; tick(3); enc_a = 1'b1; tick(3);
      enc_b = 1'b0; tick(3); enc_a = 1'b0; tick(3);
    end
    tick(4);
    chk(position == 16'sd3, "R4", "reverse count", int'(position), 3);

    // R6: simultaneous rise, A sampled high -> up, single step
    enc_a = 1'b1; enc_b = 1'b1; tick(4);
    chk(position == 16'sd4, "R6", "single step", int'(position), 4);
    chk(dir_up == 1'b1, "R3", "dir from A high", int'(dir_up), 1);
    // R4: falling edges have no effect
    enc_a = 1'b0; enc_b = 1'b0; tick(4);
    chk(position == 16'sd4 && !step_valid, "R4", "falling ignored", int'(position), 4);

    // R9: clear overrides a due step, resets direction
    enc_b = 1'b1; tick(4); enc_b = 1'b0; tick(4);
    chk(dir_up == 1'b0 && position == 16'sd3, "R3", "down before clear", int'(position), 3);
    enc_a = 1'b1; tick(2);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk(position == 16'sd0, "R9", "clear position", int'(position), 0);
    chk(dir_up == 1'b1, "R9", "clear dir", int'(dir_up), 1);
    chk(step_valid == 1'b0, "R9", "clear strobe", int'(step_valid), 0);
    tick(1);
    chk(position == 16'sd0, "R9", "step swallowed", int'(position), 0);
    enc_a = 1'b0; tick(4);

    // R7: 0 - 1 wraps to 0xFFFF
    enc_b = 1'b1; tick(4); enc_b = 1'b0; tick(4);
    chk(position == -16'sd1, "R7", "wrap below zero", int'(position), 16'hFFFF);
    clr = 1'b1; tick(1); clr = 1'b0;
    for (int i = 0; i < 32767; i++) begin
      enc_a = 1'b1; tick(1); enc_a = 1'b0; tick(1);
    end
    tick(4);
    chk(position == 16'sh7FFF, "R7", "max positive", int'(position), 16'h7FFF);
    enc_a = 1'b1; tick(1); enc_a = 1'b0; tick(4);
    chk(position == 16'sh8000, "R7", "wrap to min", int'(position), 16'h8000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule